// File: doc/BRIEF.md
# Software Doorbell Interrupt Controller

This block raises machine software interrupts between harts through a memory-mapped register file that works like a platform interrupt controller. Each hart `h` has its own doorbell source, number `h + 1`. Source number zero is reserved and never exists. Any hart, including the target hart itself, rings a doorbell by writing a one into the matching bit of a write-one-to-set pending array. The target's interrupt line is high while at least one source is pending, is enabled for that hart, has a nonzero priority, and is not already being serviced by that hart.

A hart services an interrupt by reading its claim/complete register. The read returns the winning source ID and clears that source's pending bit. The source is then in service for that hart until the hart writes the same ID back to the same register. Priorities choose between several pending sources. The block has no external interrupt inputs and no per-hart threshold. All traffic uses a single-cycle register bus with registered read data.

Top module: `swi_doorbell_ctrl`

## Requirements
- R1: Source n (1 ≤ n ≤ NUM_HARTS) has a priority word at byte offset 4·n. The low PRIO_W bits are stored and the upper bits read zero. Offset 0x0 reads zero.
- R2: Source n is bit n%32 of the pending word at offset 0x1000 + 4·(n/32). Writing a one sets that bit. Writing a zero leaves it unchanged.
- R3: Source 0 cannot be set. Bit 0 of pending word 0 and bit 0 of every hart's enable word 0 always read zero, and writes to those bits are ignored.
- R4: Hart h has read/write enable words at offset 0x2000 + 0x80·h + 4·w. Bit b of word w enables source 32·w + b. Bits above the last source read zero.
- R5: msip_o[h] is high exactly when some source is pending, enabled for hart h, has nonzero priority, and is not in service for hart h. The output follows a register write on the clock edge that takes the write.
- R6: Reading offset 0x200000 + 0x1000·h + 0x4 returns the eligible source for hart h (same conditions as R5) with the highest priority. Ties go to the lowest ID. The read returns 0 when no source is eligible, and clears the pending bit of the source it returns.
- R7: A source that hart h has claimed is not presented to hart h again, even if it becomes pending again, until hart h writes that source's ID to its claim/complete register.
- R8: A completion write that names a source not enabled for that hart, or an ID outside 1..NUM_HARTS, has no effect.
- R9: Reads of unmapped offsets return zero, and writes to unmapped offsets change no state.
- R10: Reset (rst_n low at a clock edge) clears every priority, pending, enable and in-service bit, clears the read data, and drives msip_o low.
- R11: Read data appears on bus_rdata after the clock edge that accepts the read. It holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| msip_o | output | NUM_HARTS | Machine software interrupt, one per hart |

## Verification
Each bus operation takes effect on the one clock edge that samples it. A write to a priority, pending, enable or completion register changes msip_o right after that edge. A read returns its data on bus_rdata right after that edge, and a claim's clearing of the pending bit and setting of the in-service bit happen on that same edge. The bench drives every request on a falling edge and releases it on the next falling edge. It reads both bus_rdata and msip_o at that second falling edge, one full register stage after the request and halfway between active edges. The bench compares every result with an arithmetic model of the priority, pending, enable and in-service state, sweeping all 32 doorbells.

// File: rtl/swi_pkg.sv
// Shared definitions for the software doorbell interrupt controller.
// Assumes a 22-bit byte address and 32-bit data words.
package swi_pkg;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 32;

    // Which register bank a bus address selects
    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_PRIO  = 3'd1,
        RG_PEND  = 3'd2,
        RG_EN    = 3'd3,
        RG_CLAIM = 3'd4
    } region_e;

    // Decoded bus access: bank, hart index, word/source index
    typedef struct packed {
        region_e     rg;
        logic [8:0]  hart;
        logic [9:0]  idx;
    } decode_t;
endpackage

// File: rtl/swi_addr_decode.sv
// Address decoder: maps a byte offset onto a register bank.
// Misaligned offsets and out-of-range indices decode to RG_NONE.
module swi_addr_decode
    import swi_pkg::*;
#(
    parameter int NUM_HARTS = 32,
    parameter int NSRC      = NUM_HARTS + 1,
    parameter int WORDS     = (NSRC + 31) / 32
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    // Select bank and check index bounds
    always_comb begin
        dec = '{rg: RG_NONE, hart: '0, idx: '0};
        if (addr[1:0] == 2'b00) begin
            if (addr[21:12] == 10'd0) begin
                dec.idx = addr[11:2];
                if (dec.idx != 10'd0 && int'(dec.idx) < NSRC) dec.rg = RG_PRIO;
            end else if (addr[21:12] == 10'd1) begin
                dec.idx = addr[11:2];
                if (int'(dec.idx) < WORDS) dec.rg = RG_PEND;
            end else if (addr[21:12] == 10'd2) begin
                dec.hart = {4'd0, addr[11:7]};
                dec.idx  = {5'd0, addr[6:2]};
                if (int'(dec.hart) < NUM_HARTS && int'(dec.idx) < WORDS) dec.rg = RG_EN;
            end else if (addr[21] && addr[11:0] == 12'h004) begin
                dec.hart = addr[20:12];
                if (int'(dec.hart) < NUM_HARTS) dec.rg = RG_CLAIM;
            end
        end
    end
endmodule

// File: rtl/swi_pick.sv
// Priority picker: returns the candidate with the highest priority,
// lowest ID on ties. Priority 0 never wins. Returns 0 if nothing qualifies.
module swi_pick #(
    parameter int NSRC   = 33,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    output logic [ID_W-1:0]        win_id
);
    logic [PRIO_W-1:0] best_p;

    // Linear scan; strict greater-than keeps the lowest ID on ties
    always_comb begin
        win_id = '0;
        best_p = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (cand[n] && prio_flat[n*PRIO_W +: PRIO_W] > best_p) begin
                best_p = prio_flat[n*PRIO_W +: PRIO_W];
                win_id = ID_W'(n);
            end
        end
    end
endmodule

// File: rtl/swi_hart_ctx.sv
// Per-hart context: holds the enable bits and the in-service bits,
// selects the winning source and drives the hart's interrupt line.
// Assumes at most one bus operation per cycle.
module swi_hart_ctx #(
    parameter int NSRC   = 33,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic [NSRC-1:0]        pend,
    input  logic                   en_wr,
    input  logic [9:0]             en_word,
    input  logic [31:0]            wdata,
    input  logic                   cpl_wr,
    input  logic                   claim_rd,
    output logic [NSRC-1:0]        en_vec,
    output logic [ID_W-1:0]        claim_id,
    output logic                   irq
);
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] busy_q;
    logic [NSRC-1:0] cand;

    // Eligible sources: pending, enabled, not already in service here
    assign cand   = pend & en_q & ~busy_q;
    assign en_vec = en_q;
    assign irq    = (claim_id != '0);

    swi_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
        .cand      (cand),
        .prio_flat (prio_flat),
        .win_id    (claim_id)
    );

    // Enable writes, claim marks in service, completion releases it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            busy_q <= '0;
        end else begin
            for (int b = 1; b < NSRC; b++) begin
                if (en_wr && (b / 32) == int'(en_word)) en_q[b] <= wdata[b % 32];
            end
            if (claim_rd && claim_id != '0) busy_q[claim_id] <= 1'b1;
            if (cpl_wr && wdata < 32'(NSRC) && en_q[wdata[ID_W-1:0]])
                busy_q[wdata[ID_W-1:0]] <= 1'b0;
        end
    end
endmodule

// File: rtl/swi_doorbell_ctrl.sv
// Top level: software doorbell interrupt controller. Holds the priority and
// pending registers, one context per hart, and the registered read port.
// Source h+1 is hart h's doorbell; source 0 does not exist.
module swi_doorbell_ctrl
    import swi_pkg::*;
#(
    parameter int NUM_HARTS = 32,
    parameter int PRIO_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_HARTS-1:0] msip_o
);
    localparam int NSRC  = NUM_HARTS + 1;
    localparam int WORDS = (NSRC + 31) / 32;
    localparam int ID_W  = $clog2(NSRC);

    logic [NSRC*PRIO_W-1:0] prio_q;
    logic [NSRC-1:0]        pend_q;
    logic [NSRC-1:0]        en_vecs   [NUM_HARTS];
    logic [ID_W-1:0]        claim_ids [NUM_HARTS];
    logic [ID_W-1:0]        sel_claim;
    logic [NSRC-1:0]        sel_en;
    logic [DATA_W-1:0]      rd_next;
    decode_t                dec;
    logic                   wr, rd;

    assign wr = bus_valid && bus_we;
    assign rd = bus_valid && !bus_we;

    swi_addr_decode #(.NUM_HARTS(NUM_HARTS), .NSRC(NSRC), .WORDS(WORDS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // One context per hart
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_ctx
        swi_hart_ctx #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .prio_flat (prio_q),
            .pend      (pend_q),
            .en_wr     (wr && dec.rg == RG_EN && int'(dec.hart) == h),
            .en_word   (dec.idx),
            .wdata     (bus_wdata),
            .cpl_wr    (wr && dec.rg == RG_CLAIM && int'(dec.hart) == h),
            .claim_rd  (rd && dec.rg == RG_CLAIM && int'(dec.hart) == h),
            .en_vec    (en_vecs[h]),
            .claim_id  (claim_ids[h]),
            .irq       (msip_o[h])
        );
    end

    // Pick the addressed hart's claim winner and enable vector
    always_comb begin
        sel_claim = '0;
        sel_en    = '0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (int'(dec.hart) == h) begin
                sel_claim = claim_ids[h];
                sel_en    = en_vecs[h];
            end
        end
    end

    // Priority writes, write-one-to-set pending, claim clears pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            pend_q <= '0;
        end else begin
            for (int n = 1; n < NSRC; n++) begin
                if (wr && dec.rg == RG_PRIO && int'(dec.idx) == n)
                    prio_q[n*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
                if (wr && dec.rg == RG_PEND && int'(dec.idx) == n / 32 && bus_wdata[n % 32])
                    pend_q[n] <= 1'b1;
            end
            if (rd && dec.rg == RG_CLAIM && sel_claim != '0) pend_q[sel_claim] <= 1'b0;
        end
    end

    // Read data for the addressed register
    always_comb begin
        rd_next = '0;
        case (dec.rg)
            RG_PRIO: begin
                for (int n = 1; n < NSRC; n++)
                    if (int'(dec.idx) == n) rd_next = DATA_W'(prio_q[n*PRIO_W +: PRIO_W]);
            end
            RG_PEND: begin
                for (int n = 1; n < NSRC; n++)
                    if (int'(dec.idx) == n / 32) rd_next[n % 32] = pend_q[n];
            end
            RG_EN: begin
                for (int n = 1; n < NSRC; n++)
                    if (int'(dec.idx) == n / 32) rd_next[n % 32] = sel_en[n];
            end
            RG_CLAIM: rd_next = DATA_W'(sel_claim);
            default:  rd_next = '0;
        endcase
    end

    // Read data register, loaded only on an accepted read
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/swi_doorbell_chk.sv
// Checker for swi_doorbell_ctrl: port-level timing and invariant properties.
module swi_doorbell_chk #(
    parameter int NUM_HARTS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_we,
    input logic [21:0]          bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_HARTS-1:0] msip_o
);
    localparam int NSRC = NUM_HARTS + 1;

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (msip_o == '0 && bus_rdata == '0));

    // R9
    unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_addr == 22'h000000) |=> bus_rdata == '0);

    // R3
    src0_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_addr == 22'h001000) |=> !bus_rdata[0]);

    // R6
    claim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_addr[21] && bus_addr[11:0] == 12'h004)
        |=> bus_rdata < 32'(NSRC));

    // R2
    pend_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == 22'h001000 && bus_wdata == '0)
        |=> $stable(msip_o));

    // R5
    msip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((msip_o & ~$past(msip_o)) != '0) |-> $past(bus_valid && bus_we));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> $stable(bus_rdata));
endmodule

bind swi_doorbell_ctrl swi_doorbell_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .msip_o    (msip_o)
);

// File: tb/sim_swi_doorbell_ctrl.sv
`timescale 1ns/1ps
module sim_swi_doorbell_ctrl;
    localparam int NH = 32;
    localparam int NS = NH + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [21:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NH-1:0] msip_o;

    int checks = 0;
    int fails  = 0;

    int prio_m [NS];
    bit pend_m [NS];
    bit en_m   [NH][NS];
    bit busy_m [NH][NS];

    always #10 clk = ~clk;

    swi_doorbell_ctrl #(.NUM_HARTS(NH), .PRIO_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msip_o(msip_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int best(int h);
        int bi = 0;
        int bp = 0;
        for (int n = 1; n < NS; n++)
            if (pend_m[n] && en_m[h][n] && !busy_m[h][n] && prio_m[n] > bp) begin
                bp = prio_m[n];
                bi = n;
            end
        return bi;
    endfunction

    function automatic logic [31:0] msip_exp();
        logic [31:0] r = '0;
        for (int h = 0; h < NH; h++) r[h] = (best(h) != 0);
        return r;
    endfunction

    function automatic logic [31:0] pend_word(int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++)
            if (32*w + b >= 1 && 32*w + b < NS) r[b] = pend_m[32*w + b];
        return r;
    endfunction

    function automatic logic [31:0] en_word(int h, int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++)
            if (32*w + b >= 1 && 32*w + b < NS) r[b] = en_m[h][32*w + b];
        return r;
    endfunction

    task automatic bus_op(bit we, logic [21:0] a, logic [31:0] d, output logic [31:0] rv);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        rv = bus_rdata;
    endtask

    task automatic chk_msip(string req);
        chk(req, 32'(msip_o), msip_exp());
    endtask

    task automatic set_prio(int n, logic [31:0] v);
        logic [31:0] rv;
        bus_op(1'b1, 22'(4*n), v, rv);
        prio_m[n] = int'(v & 32'h7);
        chk_msip("R5 msip after priority write");
    endtask

    task automatic set_pend(int w, logic [31:0] v);
        logic [31:0] rv;
        bus_op(1'b1, 22'h001000 + 22'(4*w), v, rv);
        for (int b = 0; b < 32; b++)
            if (32*w + b >= 1 && 32*w + b < NS && v[b]) pend_m[32*w + b] = 1'b1;
        chk_msip("R5 msip after pending write");
    endtask

    task automatic set_en(int h, int w, logic [31:0] v);
        logic [31:0] rv;
        bus_op(1'b1, 22'h002000 + 22'(128*h) + 22'(4*w), v, rv);
        for (int b = 0; b < 32; b++)
            if (32*w + b >= 1 && 32*w + b < NS) en_m[h][32*w + b] = v[b];
        chk_msip("R5 msip after enable write");
    endtask

    task automatic complete(int h, int id);
        logic [31:0] rv;
        bus_op(1'b1, 22'h200000 + 22'(4096*h) + 22'h4, 32'(id), rv);
        if (id >= 1 && id < NS && en_m[h][id]) busy_m[h][id] = 1'b0;
        chk_msip("R7 msip after completion");
    endtask

    task automatic claim(int h, string req, output int got);
        logic [31:0] rv;
        int exp = best(h);
        bus_op(1'b0, 22'h200000 + 22'(4096*h) + 22'h4, '0, rv);
        chk(req, rv, 32'(exp));
        if (exp != 0) begin
            pend_m[exp] = 1'b0;
            busy_m[h][exp] = 1'b1;
        end
        got = int'(rv);
        chk_msip("R6 msip after claim");
    endtask

    task automatic rd_chk(logic [21:0] a, logic [31:0] exp, string req);
        logic [31:0] rv;
        bus_op(1'b0, a, '0, rv);
        chk(req, rv, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int got;
        logic [31:0] rv;
        int ids [16];
        int nid;
        for (int n = 0; n < NS; n++) begin
            prio_m[n] = 0;
            pend_m[n] = 1'b0;
        end
        for (int h = 0; h < NH; h++)
            for (int n = 0; n < NS; n++) begin
                en_m[h][n] = 1'b0;
                busy_m[h][n] = 1'b0;
            end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 msip after reset", 32'(msip_o), 32'h0);
        chk("R10 rdata after reset", bus_rdata, 32'h0);
        rd_chk(22'h000004, 32'h0, "R10 priority reset");
        rd_chk(22'h001000, 32'h0, "R10 pending word0 reset");
        rd_chk(22'h001004, 32'h0, "R10 pending word1 reset");
        rd_chk(22'h002000, 32'h0, "R10 enable reset");
        rd_chk(22'h200004, 32'h0, "R10 claim reset");

        // R1: priority width masking, sweep of all sources
        for (int n = 1; n < NS; n++) begin
            set_prio(n, 32'hFFFF_FFF8 | 32'((n * 5) % 8));
            rd_chk(22'(4*n), 32'((n * 5) % 8), "R1 priority readback");
        end
        rd_chk(22'h000000, 32'h0, "R1 offset zero reads zero");

        // R2 R4 R5 R6 R7: each hart's doorbell in turn
        for (int h = 0; h < NH; h++) begin
            set_en(h, (h + 1) / 32, 32'h1 << ((h + 1) % 32));
            rd_chk(22'h002000 + 22'(128*h) + 22'(4*((h + 1) / 32)),
                   en_word(h, (h + 1) / 32), "R4 enable readback");
            set_pend((h + 1) / 32, 32'h1 << ((h + 1) % 32));
            rd_chk(22'h001000 + 22'(4*((h + 1) / 32)),
                   pend_word((h + 1) / 32), "R2 pending bit position");
            claim(h, "R6 doorbell claim", got);
            if (got != 0) complete(h, got);
        end
        // zero-priority doorbells stay quiet; give them a priority now
        for (int n = 8; n < NS; n += 8) begin
            set_prio(n, 32'h2);
            claim(n - 1, "R5 zero-priority source raised later", got);
            if (got != 0) complete(n - 1, got);
        end

        // R3: source 0 bits
        set_pend(0, 32'h1);
        rd_chk(22'h001000, pend_word(0), "R3 pending bit0 stays zero");
        set_en(0, 0, 32'hFFFF_FFFF);
        rd_chk(22'h002000, 32'hFFFF_FFFE, "R3 enable bit0 stays zero");
        set_en(0, 1, 32'hFFFF_FFFF);
        rd_chk(22'h002004, 32'h0000_0001, "R4 enable bits above last source");

        // R6: arbitration across many pending sources on hart 0
        set_pend(0, 32'h0000_1FFE);
        nid = 0;
        for (int k = 0; k < 16; k++) begin
            claim(0, "R6 priority order", got);
            if (got == 0) break;
            ids[nid] = got;
            nid++;
        end
        chk("R6 claim count", 32'(nid), 32'd12);
        for (int k = 0; k < nid; k++) complete(0, ids[k]);

        // R7: in-service source not presented again until completed
        set_en(0, 0, 32'h0000_0020);
        set_en(0, 1, 32'h0);
        set_pend(0, 32'h0000_0020);
        claim(0, "R7 first claim", got);
        chk("R7 claimed source 5", 32'(got), 32'd5);
        set_pend(0, 32'h0000_0020);
        chk("R7 msip low while in service", 32'(msip_o[0]), 32'h0);
        claim(0, "R7 repeat claim returns zero", got);
        complete(0, 5);
        chk("R7 msip back after completion", 32'(msip_o[0]), 32'h1);
        claim(0, "R7 claim after completion", got);

        // R8: completion for a disabled source is ignored
        set_en(0, 0, 32'h0);
        complete(0, 5);
        complete(0, 40);
        set_en(0, 0, 32'h0000_0020);
        set_pend(0, 32'h0000_0020);
        chk("R8 still in service", 32'(msip_o[0]), 32'h0);
        claim(0, "R8 claim while in service", got);
        complete(0, 5);
        claim(0, "R8 claim after valid completion", got);
        complete(0, got);

        // R9: unmapped offsets
        bus_op(1'b1, 22'h000000, 32'hFFFF_FFFF, rv);
        bus_op(1'b1, 22'h001008, 32'hFFFF_FFFF, rv);
        bus_op(1'b1, 22'h002008, 32'hFFFF_FFFF, rv);
        bus_op(1'b1, 22'h003000, 32'hFFFF_FFFF, rv);
        bus_op(1'b1, 22'h200000, 32'hFFFF_FFFF, rv);
        chk_msip("R9 msip unchanged by unmapped writes");
        rd_chk(22'h001000, pend_word(0), "R9 pending unchanged");
        rd_chk(22'h002000, en_word(0, 0), "R9 enable unchanged");
        rd_chk(22'h001008, 32'h0, "R9 unmapped pending word");
        rd_chk(22'h003000, 32'h0, "R9 unmapped page");
        rd_chk(22'h200008, 32'h0, "R9 unmapped context offset");
        rd_chk(22'h220004, 32'h0, "R9 claim of missing hart");

        // R2: zero write has no effect
        set_pend(0, 32'h0000_0004);
        set_pend(0, 32'h0);
        rd_chk(22'h001000, pend_word(0), "R2 zero write keeps bits");

        // R11: read data holds between reads
        rd_chk(22'h000008, 32'(prio_m[2]), "R11 read value");
        repeat (3) @(negedge clk);
        chk("R11 rdata held", bus_rdata, 32'(prio_m[2]));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule